// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block is the timekeeping core of a real-time clock. It stores seconds, minutes, hours, day of week, date of month, month with a century flag, and two-digit year as packed BCD bytes, and it moves them forward once per second. A free-running prescaler supplies that one-second step. The prescaler counts pulses on a 32.768 kHz enable input and also drives a 1 Hz phase reference. Hours are kept in either the 24-hour or the 12-hour form, and a mode bit inside the hours byte chooses between them. At the end of each month the date rolls over according to that month's length. February receives a 29th day when the year is a multiple of four. When the year passes 99, a century flag in the month byte toggles.

Software sets the time through a single-cycle load port, which carries a field address and a data byte. The addressed field takes the new value on the next clock edge. Any load into the seconds field also restarts the prescaler. After that restart, the phase reference rises half a second later and the next advance comes one full second later.

Top module: `rtc_core`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, hour 00 in 24-hour mode, day of week 1, date 01, month 01 with the century flag (month bit 7) clear, and year 00. The phase reference is low.
- R2: Seconds and minutes count 00 to 59 in BCD. Each field wraps from 59 to 00 and carries into the next field. Seconds advance once every 2^DIV_W enable pulses.
- R3: In 24-hour mode (hours bit 6 = 0), bits 5 and 4 hold the tens digit (bit 5 = 2, bit 4 = 1). Hours count 00 to 23, and the step from 23:59:59 goes to 00:00:00.
- R4: In 12-hour mode (hours bit 6 = 1), bit 5 is PM and bit 4 is the tens digit. The hour order is 12, 1, ..., 11, and PM toggles on the step from 11 to 12. Midnight, which advances the day, is the step from 11 PM to 12 AM.
- R5: The day of week advances at midnight and wraps from 7 back to 1.
- R6: The date wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February. The month advances on each date wrap.
- R7: February ends after day 29 when the year is a multiple of four and after day 28 otherwise.
- R8: December wraps to January and carries into the year. When the year wraps from 99 to 00, the century flag toggles in either direction.
- R9: A load with address 0..6 (seconds, minutes, hours, day, date, month, year) changes only that field, on the next edge. Address 7 changes nothing.
- R10: A seconds load restarts the prescaler. The reference stays low for the next 2^(DIV_W-1)-1 enable pulses and goes high on the following pulse. Seconds advance on enable pulse 2^DIV_W after the load.
- R11: With no enable pulses, neither the time nor the reference changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| wr_en | input | 1 | Field load strobe |
| wr_addr | input | 3 | Field address: 0 sec, 1 min, 2 hour, 3 day, 4 date, 5 month, 6 year |
| wr_data | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM/tens bit |
| wday_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month in BCD, bit 7 century flag |
| year_o | output | 8 | Year, BCD |
| sec_tick_o | output | 1 | One-cycle pulse when the time advances |
| ref_1hz_o | output | 1 | 1 Hz phase reference |

## Verification
Each test loads a time just before a boundary and then applies exactly one second of enable pulses, so every test exercises exactly one carry path. The carry patterns cover a minute carry, the 19-to-20 hour step that exposes the bit-5 tens encoding, and the 24-hour midnight step. The 12-hour tests cover the 11 AM, 12 PM and 11 PM steps, which separate the PM toggle from the midnight day advance. The date tests use 30-day and 31-day month ends, February in leap and non-leap years, and a year-99 wrap taken from both century values, so a wrong month-length table or a century flag that only sets shows up. The phase tests count pulses one short of and exactly at the half-second and full-second points, and they repeat the count after a reload in mid-second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_WDAY  = 3'd3,
        F_DATE  = 3'd4,
        F_MONTH = 3'd5,
        F_YEAR  = 3'd6,
        F_NONE  = 3'd7
    } field_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] date;
        logic [7:0] month;   // bit 7 century flag
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] hour;
        logic       midnight;
    } hour_step_t;

    localparam rtc_time_t RESET_TIME = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
        date: 8'h01, month: 8'h01, year: 8'h00
    };

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v % 7'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        logic [6:0] d;
        case (mon)
            7'd2:                      d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   d = 7'd30;
            default:                   d = 7'd31;
        endcase
        return d;
    endfunction

    function automatic hour_step_t hour_next(input logic [7:0] h);
        hour_step_t r;
        logic [6:0] v;
        logic [7:0] b;
        logic       pm;
        r.midnight = 1'b0;
        pm = h[5];
        if (h[6]) begin
            v = (h[4] ? 7'd10 : 7'd0) + 7'(h[3:0]);
            if (v == 7'd11) begin
                v = 7'd12;
                pm = ~h[5];
                r.midnight = h[5];
            end else if (v == 7'd12) begin
                v = 7'd1;
            end else begin
                v = v + 7'd1;
            end
            b = bin2bcd(v);
            r.hour = {1'b0, 1'b1, pm, b[4:0]};
        end else begin
            v = (h[5] ? 7'd20 : 7'd0) + (h[4] ? 7'd10 : 7'd0) + 7'(h[3:0]);
            if (v == 7'd23) begin
                v = 7'd0;
                r.midnight = 1'b1;
            end else begin
                v = v + 7'd1;
            end
            b = bin2bcd(v);
            r.hour = {2'b00, b[5:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic clr,
    output logic sec_tick,
    output logic ref_hi
);
    localparam logic [DIV_W-1:0] TOP = '1;

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= TOP;
        end else if (tick_en) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign sec_tick = tick_en && (cnt == '0);
    assign ref_hi   = ~cnt[DIV_W-1];

    // R10: a restart leaves the reference low
    assert_clr_ref_low_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ref_hi);

    // R11: the reference only rises on an enable pulse
    assert_ref_needs_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_hi) |-> $past(tick_en));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  logic      wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output rtc_time_t cur
);
    rtc_time_t  nxt;
    hour_step_t hs;
    logic [6:0] s_b, m_b, d_b, mo_b, y_b, last_day;

    always_comb begin
        s_b      = bcd2bin(cur.sec);
        m_b      = bcd2bin(cur.min);
        d_b      = bcd2bin(cur.date);
        mo_b     = bcd2bin({3'b000, cur.month[4:0]});
        y_b      = bcd2bin(cur.year);
        last_day = month_days(mo_b, y_b);
        hs       = hour_next(cur.hour);
        nxt      = cur;
        if (wr_en) begin
            case (field_e'(wr_addr))
                F_SEC:   nxt.sec   = {1'b0, wr_data[6:0]};
                F_MIN:   nxt.min   = {1'b0, wr_data[6:0]};
                F_HOUR:  nxt.hour  = {1'b0, wr_data[6:0]};
                F_WDAY:  nxt.wday  = {5'b0, wr_data[2:0]};
                F_DATE:  nxt.date  = {2'b0, wr_data[5:0]};
                F_MONTH: nxt.month = {wr_data[7], 2'b0, wr_data[4:0]};
                F_YEAR:  nxt.year  = wr_data;
                default: nxt = cur;
            endcase
        end else if (sec_tick) begin
            if (s_b != 7'd59) begin
                nxt.sec = bin2bcd(s_b + 7'd1);
            end else begin
                nxt.sec = 8'h00;
                if (m_b != 7'd59) begin
                    nxt.min = bin2bcd(m_b + 7'd1);
                end else begin
                    nxt.min  = 8'h00;
                    nxt.hour = hs.hour;
                    if (hs.midnight) begin
                        nxt.wday = (cur.wday == 8'd7) ? 8'd1 : cur.wday + 8'd1;
                        if (d_b != last_day) begin
                            nxt.date = bin2bcd(d_b + 7'd1);
                        end else begin
                            nxt.date = 8'h01;
                            if (mo_b != 7'd12) begin
                                nxt.month = {cur.month[7], bin2bcd(mo_b + 7'd1)[6:0]};
                            end else begin
                                nxt.month = {cur.month[7], 7'h01};
                                if (y_b != 7'd99) begin
                                    nxt.year = bin2bcd(y_b + 7'd1);
                                end else begin
                                    nxt.year     = 8'h00;
                                    nxt.month[7] = ~cur.month[7];
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= RESET_TIME;
        else     cur <= nxt;
    end

    // R2: seconds wrap to zero
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_en && cur.sec == 8'h59) |=> cur.sec == 8'h00);

    // R4: PM flips on the 11 -> 12 step
    assert_pm_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_en && cur.hour[6] && cur.hour[4:0] == 5'h11
         && cur.min == 8'h59 && cur.sec == 8'h59) |=> cur.hour[5] != $past(cur.hour[5]));

    // R3: the mode bit never moves without a load
    assert_mode_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> cur.hour[6] == $past(cur.hour[6]));

    // R5: day of week stays in 1..7
    assert_wday_range_R5: assert property (@(posedge clk) disable iff (rst)
        cur.wday != 8'd0 && cur.wday <= 8'd7);

    // R8: the century flag only flips on a 99 -> 00 year wrap
    assert_century_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && cur.month[7] != $past(cur.month[7]))
        |-> ($past(cur.year) == 8'h99 && cur.year == 8'h00));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       sec_tick_o,
    output logic       ref_1hz_o
);
    rtc_time_t t;
    logic      restart;

    assign restart = wr_en && (field_e'(wr_addr) == F_SEC);

    rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .clr     (restart),
        .sec_tick(sec_tick_o),
        .ref_hi  (ref_1hz_o)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst     (rst),
        .sec_tick(sec_tick_o),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur     (t)
    );

    assign sec_o   = t.sec;
    assign min_o   = t.min;
    assign hour_o  = t.hour;
    assign wday_o  = t.wday;
    assign date_o  = t.date;
    assign month_o = t.month;
    assign year_o  = t.year;

endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
    localparam int DIV_W = 4;
    localparam int SEC_P = 1 << DIV_W;
    localparam int HALF  = 1 << (DIV_W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
    logic sec_tick_o, ref_1hz_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_core #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .sec_tick_o(sec_tick_o), .ref_1hz_o(ref_1hz_o)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // loads all fields, seconds last so the prescaler starts a full second
    task automatic set_all(input logic [7:0] y, mo, d, wd, h, mi, s);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, wd);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic t_reset;
        chk("R1", "sec", sec_o, 8'h00);
        chk("R1", "min", min_o, 8'h00);
        chk("R1", "hour", hour_o, 8'h00);
        chk("R1", "wday", wday_o, 8'h01);
        chk("R1", "date", date_o, 8'h01);
        chk("R1", "month", month_o, 8'h01);
        chk("R1", "year", year_o, 8'h00);
        chk("R1", "ref", {7'b0, ref_1hz_o}, 8'h00);
    endtask

    task automatic t_sec_min;
        set_all(8'h21, 8'h03, 8'h10, 8'h02, 8'h05, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R2", "sec wrap", sec_o, 8'h00);
        chk("R2", "min wrap", min_o, 8'h00);
        chk("R2", "hour carry", hour_o, 8'h06);
        wr(3'd0, 8'h07);
        pulses(SEC_P);
        chk("R2", "sec 07->08", sec_o, 8'h08);
        chk("R2", "min held", min_o, 8'h00);
    endtask

    task automatic t_24h;
        set_all(8'h21, 8'h03, 8'h10, 8'h02, 8'h19, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R3", "19->20", hour_o, 8'h20);
        set_all(8'h21, 8'h03, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R3", "midnight hour", hour_o, 8'h00);
        chk("R3", "midnight date", date_o, 8'h16);
        chk("R5", "wday 7->1", wday_o, 8'h01);
    endtask

    task automatic t_12h;
        set_all(8'h21, 8'h03, 8'h10, 8'h03, 8'h51, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R4", "11AM->12PM", hour_o, 8'h72);
        chk("R4", "no day at noon", wday_o, 8'h03);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        pulses(SEC_P);
        chk("R4", "12PM->1PM", hour_o, 8'h61);
        set_all(8'h21, 8'h03, 8'h10, 8'h03, 8'h71, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R4", "11PM->12AM", hour_o, 8'h52);
        chk("R4", "date at midnight", date_o, 8'h11);
        chk("R5", "wday 3->4", wday_o, 8'h04);
    endtask

    task automatic t_month;
        set_all(8'h21, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R6", "Apr30 date", date_o, 8'h01);
        chk("R6", "Apr30 month", month_o, 8'h05);
        set_all(8'h21, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R6", "Jan30->31", date_o, 8'h31);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        pulses(SEC_P);
        chk("R6", "Jan31 date", date_o, 8'h01);
        chk("R6", "Jan31 month", month_o, 8'h02);
    endtask

    task automatic t_leap;
        set_all(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R7", "leap Feb28->29", date_o, 8'h29);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        pulses(SEC_P);
        chk("R7", "leap Feb29 date", date_o, 8'h01);
        chk("R7", "leap Feb29 month", month_o, 8'h03);
        set_all(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R7", "plain Feb28 date", date_o, 8'h01);
        chk("R7", "plain Feb28 month", month_o, 8'h03);
    endtask

    task automatic t_century;
        set_all(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R8", "year 99->00", year_o, 8'h00);
        chk("R8", "month set century", month_o, 8'h81);
        chk("R8", "date", date_o, 8'h01);
        set_all(8'h99, 8'h92, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R8", "month clear century", month_o, 8'h01);
        set_all(8'h41, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulses(SEC_P);
        chk("R8", "year 41->42", year_o, 8'h42);
        chk("R8", "Dec->Jan", month_o, 8'h01);
    endtask

    task automatic t_write;
        set_all(8'h10, 8'h06, 8'h12, 8'h04, 8'h08, 8'h15, 8'h20);
        wr(3'd1, 8'h33);
        chk("R9", "min loaded", min_o, 8'h33);
        chk("R9", "sec kept", sec_o, 8'h20);
        chk("R9", "hour kept", hour_o, 8'h08);
        chk("R9", "date kept", date_o, 8'h12);
        wr(3'd7, 8'h55);
        chk("R9", "addr7 sec", sec_o, 8'h20);
        chk("R9", "addr7 min", min_o, 8'h33);
        chk("R9", "addr7 hour", hour_o, 8'h08);
        chk("R9", "addr7 wday", wday_o, 8'h04);
        chk("R9", "addr7 date", date_o, 8'h12);
        chk("R9", "addr7 month", month_o, 8'h06);
        chk("R9", "addr7 year", year_o, 8'h10);
    endtask

    task automatic t_phase;
        wr(3'd0, 8'h10);
        pulses(HALF - 1);
        chk("R10", "ref before half", {7'b0, ref_1hz_o}, 8'h00);
        pulses(1);
        chk("R10", "ref at half", {7'b0, ref_1hz_o}, 8'h01);
        pulses(HALF - 1);
        chk("R10", "sec before full", sec_o, 8'h10);
        pulses(1);
        chk("R10", "sec at full", sec_o, 8'h11);
        chk("R10", "ref after wrap", {7'b0, ref_1hz_o}, 8'h00);
        pulses(HALF + 3);
        wr(3'd0, 8'h20);
        chk("R10", "ref after reload", {7'b0, ref_1hz_o}, 8'h00);
        pulses(SEC_P - 1);
        chk("R10", "no early advance", sec_o, 8'h20);
        pulses(1);
        chk("R10", "advance after reload", sec_o, 8'h21);
    endtask

    task automatic t_gate;
        wr(3'd0, 8'h30);
        pulses(HALF);
        repeat (100) @(negedge clk);
        chk("R11", "sec held", sec_o, 8'h30);
        chk("R11", "ref held", {7'b0, ref_1hz_o}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_sec_min;
        t_24h;
        t_12h;
        t_month;
        t_leap;
        t_century;
        t_write;
        t_phase;
        t_gate;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule